// File: doc/BRIEF.md
# EEPROM Page Burst Programmer

This block sits on the host side of a byte-wide parallel EEPROM and programs one page of it per command. A command names the page (the upper eight address bits), how many bytes to write (1 to 32) and how the end of programming is to be detected. The bytes then stream into a small internal buffer. Once the buffer holds the whole burst, the block replays it to the memory as a train of write-enable strobes. Setup, pulse and recovery times are set by parameters in clock cycles, and the strobes come close enough together that the device's byte-load window never closes in the middle of a burst.

After the last strobe the block does not wait a fixed worst-case time. It reads the device again and again. In toggle mode it stops when two reads in a row return the same value on data bit 6. In polling mode it reads the last address written and stops when data bit 7 matches the bit 7 that was written there. If neither happens within `TIMEOUT_CYC` cycles of polling, the block reports an error and gives up. Either way it pulses `done` for one cycle and goes back to idle.

Both inbound interfaces are valid/ready. `cmd_ready` is high only while the block is idle, so a command offered at any other time is held off by back-pressure. `dat_ready` is high only while bytes are being collected, so a source may drop `dat_valid` between bytes and the block simply waits. `busy`, `done` and `err` are plain status pins.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset the block is idle. `cmd_ready`=1, `busy`=0, `dat_ready`=0, `done`=0. The memory pins are inactive: `mem_ce_n`, `mem_we_n` and `mem_oe_n` are all 1, and `mem_dq_oe`=0.
- R2: A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. From then until the end of the command, `cmd_ready` is 0 and `busy` is 1. `dat_ready` is 1 only while bytes are being collected, and exactly `cmd_len` bytes are taken. The source may stall between bytes.
- R3: Byte i of a burst is written at address `{cmd_page, i[4:0]}`, in the order i = 0 to `cmd_len`-1. Every strobe in the burst therefore shares address bits 12..5. Address and data stay stable while `mem_we_n` is low.
- R4: While `mem_we_n` is low, `mem_oe_n` is high and `mem_ce_n` is low. Whenever `mem_oe_n` is low, `mem_dq_oe` is 0.
- R5: Each write-enable low pulse lasts at least `WE_LOW_CYC` cycles. Data is driven at least `DATA_SETUP_CYC` cycles before the rising edge. The block waits at least `WE_HIGH_CYC` cycles after that edge before presenting the next byte.
- R6: No gap from one write-enable rising edge to the next falling edge in the same burst exceeds the device's byte-load window.
- R7: With `cmd_mode`=0 (toggle), completion is declared only after two back-to-back reads return equal data bit 6.
- R8: With `cmd_mode`=1 (polling), reads go to the last written address. Completion is declared when read bit 7 equals the bit 7 of the last byte written.
- R9: If completion is not seen within `TIMEOUT_CYC` cycles of polling, `err` is 1 in the `done` cycle and the block returns to idle.
- R10: Bursts of 1 byte and of 32 bytes both program every byte correctly.
- R11: `done` is a single-cycle pulse. `err` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle if valid (idle) |
| cmd_page | input | 8 | Page number, becomes address bits 12..5 |
| cmd_len | input | 6 | Number of bytes, 1 to 32 |
| cmd_mode | input | 1 | 0 = toggle detection, 1 = polling detection |
| dat_valid | input | 1 | Data byte offered |
| dat_ready | output | 1 | Data byte accepted this cycle if valid |
| dat_byte | input | 8 | Data byte, in address order |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse at the end of a command |
| err | output | 1 | High with `done` when polling timed out |
| mem_addr | output | 13 | Memory address |
| mem_dq_o | output | 8 | Write data to memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 8 | Read data from memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
A wrong buffer index or page register shows up as a wrong byte at a wrong address. The bench catches it by reading the memory model right after the `done` pulse. A wrong phase count shows up on the pins as a shortened write-enable pulse or a too-long gap, which the bench sees at the very next rising edge. A detector that compares too early raises `done` while the model is still programming, which is caught in that same `done` cycle. A broken timeout either hangs the block, which only the watchdog ends, or clears `err`, which is caught at the `done` that ends the stuck command.

// File: rtl/epw_pkg.sv
package epw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FILL,
    ST_ARM,
    ST_STROBE,
    ST_RECOVER,
    ST_PROBE,
    ST_SETTLE,
    ST_FINISH
  } epw_state_e;

  typedef enum logic {
    DET_TOGGLE = 1'b0,
    DET_POLL   = 1'b1
  } epw_det_e;

  function automatic int unsigned epw_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/epw_tick_timer.sv
module epw_tick_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] cnt;

  // expires after `limit` cycles spent since the last restart
  assign expired = (cnt >= (limit - W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (!expired) cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/epw_page_buf.sv
module epw_page_buf #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [DATA_W-1:0] slot;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g))) slot <= wr_data;
    end
    assign cells[g] = slot;
  end

  assign rd_data = cells[rd_idx];

endmodule

// File: rtl/epw_done_detect.sv
module epw_done_detect #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              advance,
  input  logic              mode,
  input  logic              want_msb,
  output logic              hit
);
  import epw_pkg::*;

  localparam int MSB_BIT = DATA_W - 1;
  localparam int TOG_BIT = DATA_W - 2;

  logic [DATA_W-1:0] sample;
  logic              prev_tog;
  logic              prev_ok;

  always_comb begin
    if (epw_det_e'(mode) == DET_POLL) hit = (sample[MSB_BIT] == want_msb);
    else                              hit = prev_ok && (sample[TOG_BIT] == prev_tog);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample   <= '0;
      prev_tog <= 1'b0;
      prev_ok  <= 1'b0;
    end else begin
      if (capture) sample <= rd_data;
      if (clear) begin
        prev_ok <= 1'b0;
      end else if (advance) begin
        prev_tog <= sample[TOG_BIT];
        prev_ok  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int PAGE_W         = 8,
  parameter int OFS_W          = 5,
  parameter int DATA_W         = 8,
  parameter int ADDR_SETUP_CYC = 1,
  parameter int WE_LOW_CYC     = 10,
  parameter int WE_HIGH_CYC    = 5,
  parameter int DATA_SETUP_CYC = 5,
  parameter int READ_CYC       = 16,
  parameter int READ_GAP_CYC   = 2,
  parameter int TIMEOUT_CYC    = 1000000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [PAGE_W-1:0]       cmd_page,
  input  logic [OFS_W:0]          cmd_len,
  input  logic                    cmd_mode,
  input  logic                    dat_valid,
  output logic                    dat_ready,
  input  logic [DATA_W-1:0]       dat_byte,
  output logic                    busy,
  output logic                    done,
  output logic                    err,
  output logic [PAGE_W+OFS_W-1:0] mem_addr,
  output logic [DATA_W-1:0]       mem_dq_o,
  output logic                    mem_dq_oe,
  input  logic [DATA_W-1:0]       mem_dq_i,
  output logic                    mem_ce_n,
  output logic                    mem_we_n,
  output logic                    mem_oe_n
);
  import epw_pkg::*;

  localparam int STROBE_CYC = epw_max(WE_LOW_CYC, DATA_SETUP_CYC);
  localparam int PH_MAX     = epw_max(epw_max(ADDR_SETUP_CYC, STROBE_CYC),
                                      epw_max(WE_HIGH_CYC, epw_max(READ_CYC, READ_GAP_CYC)));
  localparam int PH_W       = $clog2(PH_MAX + 1);
  localparam int TO_W       = $clog2(TIMEOUT_CYC + 1);

  epw_state_e          state, state_nx;
  logic [PAGE_W-1:0]   page_q;
  logic [OFS_W-1:0]    last_q;
  logic [OFS_W-1:0]    idx_q;
  logic                mode_q;
  logic                want_msb_q;
  logic                err_q;

  logic [PH_W-1:0]     ph_limit;
  logic                ph_exp;
  logic                to_exp;
  logic                det_hit;
  logic [DATA_W-1:0]   buf_rd;
  logic                take_cmd, take_dat, at_last, read_phase, write_phase;

  assign take_cmd    = (state == ST_IDLE) && cmd_valid;
  assign take_dat    = (state == ST_FILL) && dat_valid;
  assign at_last     = (idx_q == last_q);
  assign read_phase  = (state == ST_PROBE) || (state == ST_SETTLE);
  assign write_phase = (state == ST_ARM) || (state == ST_STROBE) || (state == ST_RECOVER);

  // ---------------- phase length per state ----------------
  always_comb begin
    case (state)
      ST_ARM:     ph_limit = PH_W'(ADDR_SETUP_CYC);
      ST_STROBE:  ph_limit = PH_W'(STROBE_CYC);
      ST_RECOVER: ph_limit = PH_W'(WE_HIGH_CYC);
      ST_PROBE:   ph_limit = PH_W'(READ_CYC);
      ST_SETTLE:  ph_limit = PH_W'(READ_GAP_CYC);
      default:    ph_limit = PH_W'(1);
    endcase
  end

  epw_tick_timer #(.W(PH_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_nx != state),
    .limit   (ph_limit),
    .expired (ph_exp)
  );

  epw_tick_timer #(.W(TO_W)) u_timeout (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (!read_phase),
    .limit   (TO_W'(TIMEOUT_CYC)),
    .expired (to_exp)
  );

  epw_page_buf #(.IDX_W(OFS_W), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (take_dat),
    .wr_idx  (idx_q),
    .wr_data (dat_byte),
    .rd_idx  (idx_q),
    .rd_data (buf_rd)
  );

  epw_done_detect #(.DATA_W(DATA_W)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (take_cmd),
    .capture  ((state == ST_PROBE) && ph_exp),
    .rd_data  (mem_dq_i),
    .advance  ((state == ST_SETTLE) && ph_exp),
    .mode     (mode_q),
    .want_msb (want_msb_q),
    .hit      (det_hit)
  );

  // ---------------- sequencing ----------------
  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:    if (cmd_valid)            state_nx = ST_FILL;
      ST_FILL:    if (dat_valid && at_last) state_nx = ST_ARM;
      ST_ARM:     if (ph_exp)               state_nx = ST_STROBE;
      ST_STROBE:  if (ph_exp)               state_nx = ST_RECOVER;
      ST_RECOVER: if (ph_exp)               state_nx = at_last ? ST_PROBE : ST_ARM;
      ST_PROBE:   if (ph_exp)               state_nx = ST_SETTLE;
      ST_SETTLE:  if (ph_exp)               state_nx = (det_hit || to_exp) ? ST_FINISH : ST_PROBE;
      ST_FINISH:                            state_nx = ST_IDLE;
      default:                              state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      page_q     <= '0;
      last_q     <= '0;
      idx_q      <= '0;
      mode_q     <= 1'b0;
      want_msb_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state <= state_nx;
      if (take_cmd) begin
        page_q <= cmd_page;
        last_q <= OFS_W'(cmd_len - (OFS_W+1)'(1));
        mode_q <= cmd_mode;
        idx_q  <= '0;
        err_q  <= 1'b0;
      end
      if (take_dat) begin
        idx_q <= at_last ? '0 : idx_q + OFS_W'(1);
        if (at_last) want_msb_q <= dat_byte[DATA_W-1];
      end
      if ((state == ST_RECOVER) && ph_exp && !at_last) idx_q <= idx_q + OFS_W'(1);
      if ((state == ST_SETTLE) && ph_exp)              err_q <= !det_hit && to_exp;
    end
  end

  // ---------------- pins ----------------
  assign cmd_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign dat_ready = (state == ST_FILL);
  assign done      = (state == ST_FINISH);
  assign err       = (state == ST_FINISH) && err_q;

  assign mem_addr  = {page_q, (read_phase ? last_q : idx_q)};
  assign mem_dq_o  = buf_rd;
  assign mem_dq_oe = write_phase;
  assign mem_ce_n  = !(write_phase || read_phase);
  assign mem_we_n  = (state != ST_STROBE);
  assign mem_oe_n  = (state != ST_PROBE);

endmodule

// File: rtl/epw_page_writer_chk.sv
module epw_page_writer_chk #(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int WE_LOW_CYC    = 10,
  parameter int BLC_LIMIT_CYC = 10000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              dat_ready,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n
);

  localparam int RUN_W = $clog2(BLC_LIMIT_CYC + WE_LOW_CYC + 2);

  logic [RUN_W-1:0] low_run;
  logic [RUN_W-1:0] high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= '0;
    end else begin
      if (mem_we_n)              low_run <= '0;
      else if (~&low_run)        low_run <= low_run + RUN_W'(1);
      if (!mem_we_n || mem_ce_n) high_run <= '0;
      else if (~&high_run)       high_run <= high_run + RUN_W'(1);
    end
  end

  // R4
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  // R4
  bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  // R3
  strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && (low_run != '0)) |-> (low_run >= RUN_W'(WE_LOW_CYC)));

  // R6
  load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && (high_run != '0)) |-> (high_run < RUN_W'(BLC_LIMIT_CYC)));

  // R2
  cmd_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!cmd_ready && busy));

  // R2
  dat_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ready |-> (busy && !cmd_ready));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

endmodule

bind eeprom_page_writer epw_page_writer_chk #(
  .ADDR_W     (PAGE_W + OFS_W),
  .DATA_W     (DATA_W),
  .WE_LOW_CYC (WE_LOW_CYC)
) u_epw_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .dat_ready (dat_ready),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .mem_addr  (mem_addr),
  .mem_dq_o  (mem_dq_o),
  .mem_dq_oe (mem_dq_oe),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n)
);

// File: tb/test_eeprom_page_writer.sv
`timescale 1ns/1ps
module test_eeprom_page_writer;

  localparam int TO_CYC   = 3000;
  localparam int LOAD_WIN = 300;
  localparam int WE_LOW   = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_page = '0;
  logic [5:0]  cmd_len = '0;
  logic        cmd_mode = 1'b0;
  logic        dat_valid = 1'b0;
  logic        dat_ready;
  logic [7:0]  dat_byte = '0;
  logic        busy, done, err;
  logic [12:0] mem_addr;
  logic [7:0]  mem_dq_o;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_i;
  logic        mem_ce_n, mem_we_n, mem_oe_n;

  always #5 clk = ~clk;

  eeprom_page_writer #(.TIMEOUT_CYC(TO_CYC)) i_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_page(cmd_page),
    .cmd_len(cmd_len), .cmd_mode(cmd_mode),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
    .busy(busy), .done(done), .err(err),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mem_m [int];
  logic [7:0] pend [32];
  logic [31:0] pend_ok;
  logic [7:0] load_page, last_byte, rd_lat;
  logic we_q = 1'b1, oe_q = 1'b1;
  logic in_load = 1'b0, busy_m = 1'b0, tog = 1'b0;
  int load_age = 0, prog_left = 0, prog_cyc = 400, low_w = 0;

  assign mem_dq_i = rd_lat;
  initial rd_lat = 8'h00;

  task automatic start_prog();
    in_load   = 1'b0;
    busy_m    = 1'b1;
    prog_left = prog_cyc;
    tog       = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_m) begin
        if (prog_left == 0) begin
          for (int i = 0; i < 32; i++)
            if (pend_ok[i]) mem_m[{load_page, i[4:0]}] = pend[i];
          busy_m = 1'b0;
        end else prog_left--;
      end
      if (!mem_we_n) low_w++;
      if (!we_q && mem_we_n && !mem_ce_n) begin
        check("R4 oe high at strobe", {31'd0, mem_oe_n}, 32'd1);
        check("R5 we low width", {31'd0, (low_w >= WE_LOW)}, 32'd1);
        check("R6 strobe outside programming", {31'd0, busy_m}, 32'd0);
        if (in_load) check("R3 shared page bits", {24'd0, mem_addr[12:5]}, {24'd0, load_page});
        else begin
          load_page = mem_addr[12:5];
          pend_ok   = '0;
        end
        pend[mem_addr[4:0]]    = mem_dq_o;
        pend_ok[mem_addr[4:0]] = 1'b1;
        last_byte = mem_dq_o;
        in_load   = 1'b1;
        load_age  = 0;
      end
      if (mem_we_n) low_w = 0;
      if (in_load) begin
        load_age++;
        if (load_age > LOAD_WIN) start_prog();
      end
      if (oe_q && !mem_oe_n && !mem_ce_n) begin
        if (in_load) start_prog();
        if (busy_m) begin
          rd_lat = {~last_byte[7], tog, last_byte[5:0]};
          tog    = ~tog;
        end else begin
          rd_lat = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 8'hFF;
        end
      end
      we_q = mem_we_n;
      oe_q = mem_oe_n;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct packed {
    logic [7:0]   page;
    logic [5:0]   len;
    logic         mode;
    logic         xerr;
    logic [255:0] bytes;
  } item_t;

  item_t sb_q[$];

  task automatic run_page(input logic [7:0] pg, input int len, input logic md,
                          input logic [255:0] bytes, input logic xerr, input int pcyc);
    item_t it;
    it.page = pg; it.len = len[5:0]; it.mode = md; it.xerr = xerr; it.bytes = bytes;
    prog_cyc = pcyc;
    sb_q.push_back(it);
    @(negedge clk);
    cmd_page = pg; cmd_len = len[5:0]; cmd_mode = md; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 ready low after accept", {31'd0, cmd_ready}, 32'd0);
    for (int i = 0; i < len; i++) begin
      if (i % 3 == 2) begin
        dat_valid = 1'b0;
        @(negedge clk);
        check("R2 waits for stalled source", {31'd0, dat_ready}, 32'd1);
      end
      dat_valid = 1'b1;
      dat_byte  = bytes[i*8 +: 8];
      while (!dat_ready) @(negedge clk);
      @(negedge clk);
    end
    dat_valid = 1'b0;
    check("R2 no data taken after last", {31'd0, dat_ready}, 32'd0);
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sb_q.size() == 0) begin
          check("R11 unexpected done", 32'd1, 32'd0);
        end else begin
          item_t it;
          it = sb_q[0];
          check("R9 err flag", {31'd0, err}, {31'd0, it.xerr});
          if (it.xerr) begin
            check("R9 device still busy at timeout", {31'd0, busy_m}, 32'd1);
          end else begin
            if (it.mode) check("R8 done only after programming", {31'd0, busy_m}, 32'd0);
            else         check("R7 done only after programming", {31'd0, busy_m}, 32'd0);
            for (int i = 0; i < int'(it.len); i++) begin
              int a;
              a = int'({it.page, i[4:0]});
              check("R10 R3 byte programmed",
                    mem_m.exists(a) ? {24'd0, mem_m[a]} : 32'hDEAD,
                    {24'd0, it.bytes[i*8 +: 8]});
            end
          end
          @(negedge clk);
          check("R11 done is one cycle", {31'd0, done}, 32'd0);
          check("R9 back to idle", {31'd0, cmd_ready}, 32'd1);
          void'(sb_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  function automatic logic [255:0] pattern(input int seed, input int len);
    logic [255:0] v = '0;
    for (int i = 0; i < len; i++) v[i*8 +: 8] = 8'((seed * 37 + i * 29) ^ (i << 3));
    return v;
  endfunction

  initial begin
    logic [255:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cmd_ready", {31'd0, cmd_ready}, 32'd1);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 dat_ready", {31'd0, dat_ready}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 pins idle", {28'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 32'hE);

    // R10: single byte, toggle detection (R7)
    b = '0; b[7:0] = 8'hC3;
    run_page(8'h00, 1, 1'b0, b, 1'b0, 400);
    // R10: full 32-byte page, polling detection (R8)
    run_page(8'hFF, 32, 1'b1, pattern(1, 32), 1'b0, 400);
    // R7: mid-size burst, toggle
    run_page(8'h5A, 7, 1'b0, pattern(2, 7), 1'b0, 350);
    // R8: last byte bit 7 clear
    b = pattern(3, 5); b[39] = 1'b0;
    run_page(8'h13, 5, 1'b1, b, 1'b0, 300);
    // R8: last byte bit 7 set
    b = pattern(4, 2); b[15] = 1'b1;
    run_page(8'h2C, 2, 1'b1, b, 1'b0, 250);
    // R9: device never finishes
    run_page(8'h71, 3, 1'b0, pattern(5, 3), 1'b1, 1000000);

    finish_run();
  end

endmodule